// File: doc/BRIEF.md
# Latched Push-Pull PWM Controller

This block generates the gate commands for a two-phase push-pull converter. A counter divides each switching period into a ramp phase and a dead-time phase. Each has its own programmable length. During the ramp phase the counter is compared with an effective duty command. A termination latch ends the pulse and keeps it ended until the next period begins. A toggle flip-flop sends successive periods to output A and output B in turn. Both outputs are forced inactive for the whole dead-time phase.

The effective duty is the smaller of the requested duty and a soft-start level. The soft-start level climbs by a fixed step at every period end. A shutdown input stops the outputs and drains the soft-start level at twice the climb rate, so the converter comes back up gradually after release. A lockout input also stops the outputs and holds the soft-start level at zero. Both asynchronous inputs pass through a two-flop synchronizer first. A synchronous restart input ends the current period at once, so several controllers can follow one system clock. A parameter chooses whether the idle state of the outputs is low or high.

Top module: `pp_pwm_ctrl`

## Requirements
- R1: A period is a ramp phase of `ramp_len` cycles (count 0 to `ramp_len`-1) followed by a dead phase of `dead_len` cycles. Reset leaves the block in the dead phase at count 0, so the first ramp phase begins `dead_len` cycles after reset is released.
- R2: The pulse is on in each ramp cycle whose count is below the effective duty. The output is registered and follows one cycle later, so the pulse width is min(effective duty, `ramp_len`) cycles. A duty of 0 gives no pulse.
- R3: The effective duty equals the smaller of `duty_cmd` and the soft-start level.
- R4: Once a pulse has ended within a period, for any reason, neither output becomes active again until the next period start. This holds even if the duty rises or shutdown is released.
- R5: The steering flip-flop toggles at every period start, including periods that carry no pulse. The first period after reset drives `out_a`, the next drives `out_b`, and so on.
- R6: Both outputs are inactive in the cycle after any dead-phase cycle, and the two outputs are never active together.
- R7: With `OFF_HIGH`=0 an active output is 1 and an idle output is 0, including during reset. With `OFF_HIGH`=1 both outputs are the exact inverse of that.
- R8: `shdn_in` and `uvlo_in` go through a two-flop synchronizer whose reset value is asserted. Once either synchronized signal is high, both outputs are inactive from the following cycle, and a pulse stopped this way stays stopped for the rest of its period.
- R9: The soft-start level is 0 after reset and changes only at a period end. It rises by `SS_STEP`, saturating at all ones, when neither input is asserted. It falls by 2·`SS_STEP`, with a floor of 0, while shutdown is asserted.
- R10: While the synchronized lockout is high, the soft-start level is forced to 0 every cycle, with priority over shutdown.
- R11: When `sync_in` is high in a cycle, that cycle is a period end. The next cycle is ramp count 0, a period start for the latch, the steering and the soft-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ramp_len | input | CNT_W | Ramp phase length in cycles (at least 1) |
| dead_len | input | CNT_W | Dead phase length in cycles (at least 1) |
| duty_cmd | input | CNT_W | Requested pulse width in cycles |
| sync_in | input | 1 | Synchronous period restart |
| shdn_in | input | 1 | Asynchronous shutdown request |
| uvlo_in | input | 1 | Asynchronous undervoltage lockout |
| out_a | output | 1 | Phase A drive, polarity set by OFF_HIGH |
| out_b | output | 1 | Phase B drive, polarity set by OFF_HIGH |

## Verification
The assertions assume that `ramp_len` and `dead_len` are at least 1 and change only while the outputs are idle. They also assume that `sync_in` is already synchronous to the clock. The stimulus keeps the lengths fixed for the whole run. It changes duty, shutdown and lockout at the first cycle of a dead phase, so the synchronizer has settled before the period end that updates the soft-start level. The only inputs changed mid-ramp are the deliberate termination and latch probes. The restart pulse is issued inside a dead phase, so no pulse is cut by it.

// File: rtl/pp_pwm_pkg.sv
// Shared types for the push-pull PWM controller.
// Assumes: a period is made of exactly two phases, ramp then dead time.
package pp_pwm_pkg;
    typedef enum logic {
        PH_RAMP = 1'b0,
        PH_DEAD = 1'b1
    } phase_t;
endpackage

// File: rtl/pp_pwm_sync2.sv
// Two-flop synchronizer for a vector of asynchronous control levels.
// Assumes: each bit is a slow level; the reset value is "asserted" so the
// controlled logic stays safe until real input values have been sampled.
module pp_pwm_sync2 #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            logic meta_q;
            logic stab_q;
            // Two register stages per bit, forced high in reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= 1'b1;
                    stab_q <= 1'b1;
                end else begin
                    meta_q <= async_in[i];
                    stab_q <= meta_q;
                end
            end
            assign sync_out[i] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/pp_pwm_timebase.sv
// Period counter: a ramp phase of ramp_len cycles, then a dead phase of
// dead_len cycles. A synchronous restart ends the period at once.
// Assumes: both lengths are at least 1 and stay stable while in use.
module pp_pwm_timebase
    import pp_pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ramp_len,
    input  logic [CNT_W-1:0] dead_len,
    input  logic             sync_in,
    output phase_t           phase,
    output logic [CNT_W-1:0] cnt,
    output logic             period_start,
    output logic             period_end
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic ramp_last;
    logic dead_last;

    assign ramp_last    = (phase == PH_RAMP) && (cnt == ramp_len - ONE);
    assign dead_last    = (phase == PH_DEAD) && (cnt == dead_len - ONE);
    assign period_start = (phase == PH_RAMP) && (cnt == '0);
    assign period_end   = sync_in || dead_last;

    // Advance the phase counter and switch phase at each phase's last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_DEAD;
            cnt   <= '0;
        end else if (period_end) begin
            phase <= PH_RAMP;
            cnt   <= '0;
        end else if (ramp_last) begin
            phase <= PH_DEAD;
            cnt   <= '0;
        end else begin
            cnt   <= cnt + ONE;
        end
    end

    // R1
    ramp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RAMP) |-> (cnt < ramp_len));
    // R1
    dead_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DEAD) |-> (cnt < dead_len));
    // R11
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |=> (phase == PH_RAMP && cnt == '0));
endmodule

// File: rtl/pp_pwm_softstart.sv
// Soft-start level: climbs one step per period end, drains two steps per
// period end under shutdown, and is held at zero under lockout.
// Assumes: shdn and uvlo are already synchronous to clk.
module pp_pwm_softstart #(
    parameter int CNT_W   = 8,
    parameter int SS_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_end,
    input  logic             shdn,
    input  logic             uvlo,
    output logic [CNT_W-1:0] level
);
    localparam logic [CNT_W:0] STEP_W = (CNT_W+1)'(SS_STEP);
    localparam logic [CNT_W:0] DRAIN  = (CNT_W+1)'(2 * SS_STEP);
    localparam logic [CNT_W:0] TOP    = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W:0] wide;
    logic [CNT_W:0] up_sum;
    logic [CNT_W:0] dn_dif;

    assign wide   = {1'b0, level};
    assign up_sum = (wide + STEP_W > TOP) ? TOP : wide + STEP_W;
    assign dn_dif = (wide >= DRAIN) ? wide - DRAIN : '0;

    // Update the level once per period end, with lockout overriding all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else if (uvlo) begin
            level <= '0;
        end else if (period_end) begin
            level <= shdn ? dn_dif[CNT_W-1:0] : up_sum[CNT_W-1:0];
        end
    end

    // R10
    lockout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> (level == '0));
    // R9
    ss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_end && !uvlo) |=> $stable(level));
    // R9
    ss_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && !shdn && !uvlo) |=> (level >= $past(level)));
    // R9
    ss_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && shdn && !uvlo) |=> (level <= $past(level)));
endmodule

// File: rtl/pp_pwm_ctrl.sv
// Latched push-pull PWM controller. It compares the period counter with the
// smaller of duty and soft-start level, holds a termination latch until the
// next period start, and steers alternate periods to output A and output B.
// Assumes: sync_in is synchronous to clk; ramp_len and dead_len are >= 1.
module pp_pwm_ctrl
    import pp_pwm_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int SS_STEP  = 4,
    parameter bit OFF_HIGH = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ramp_len,
    input  logic [CNT_W-1:0] dead_len,
    input  logic [CNT_W-1:0] duty_cmd,
    input  logic             sync_in,
    input  logic             shdn_in,
    input  logic             uvlo_in,
    output logic             out_a,
    output logic             out_b
);
    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic             period_start;
    logic             period_end;
    logic [1:0]       ctl_s;
    logic             shdn_s;
    logic             uvlo_s;
    logic             kill;
    logic [CNT_W-1:0] ss_level;
    logic [CNT_W-1:0] eff_duty;
    logic             cmp_end;
    logic             pulse_on;
    logic             term_q;
    logic             steer_q;
    logic             sel_b;
    logic             act_a_q;
    logic             act_b_q;

    pp_pwm_sync2 #(.N(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({uvlo_in, shdn_in}),
        .sync_out (ctl_s)
    );
    assign shdn_s = ctl_s[0];
    assign uvlo_s = ctl_s[1];
    assign kill   = shdn_s || uvlo_s;

    pp_pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk          (clk),
        .rst_n        (rst_n),
        .ramp_len     (ramp_len),
        .dead_len     (dead_len),
        .sync_in      (sync_in),
        .phase        (phase),
        .cnt          (cnt),
        .period_start (period_start),
        .period_end   (period_end)
    );

    pp_pwm_softstart #(.CNT_W(CNT_W), .SS_STEP(SS_STEP)) u_ss (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_end (period_end),
        .shdn       (shdn_s),
        .uvlo       (uvlo_s),
        .level      (ss_level)
    );

    // The comparator ends the pulse outside the ramp, at the duty count, or on a kill.
    assign eff_duty = (duty_cmd < ss_level) ? duty_cmd : ss_level;
    assign cmp_end  = (phase != PH_RAMP) || (cnt >= eff_duty) || kill;
    // The latch counts as clear during the period-start cycle.
    assign pulse_on = (period_start || !term_q) && !cmp_end;
    // The new steering value applies from the period-start cycle itself.
    assign sel_b    = period_start ? !steer_q : steer_q;

    // Termination latch: cleared by the period start, set by any pulse end.
    always_ff @(posedge clk) begin
        if (!rst_n)            term_q <= 1'b1;
        else if (period_start) term_q <= cmp_end;
        else                   term_q <= term_q || cmp_end;
    end

    // Steering toggle: flips once per period start.
    always_ff @(posedge clk) begin
        if (!rst_n)            steer_q <= 1'b1;
        else if (period_start) steer_q <= !steer_q;
    end

    // Output registers: route the pulse to the side chosen for this period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_a_q <= 1'b0;
            act_b_q <= 1'b0;
        end else begin
            act_a_q <= pulse_on && !sel_b;
            act_b_q <= pulse_on && sel_b;
        end
    end

    generate
        if (OFF_HIGH) begin : g_idle_high
            assign out_a = !act_a_q;
            assign out_b = !act_b_q;
        end else begin : g_idle_low
            assign out_a = act_a_q;
            assign out_b = act_b_q;
        end
    endgenerate

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_a_q && act_b_q));
    // R6
    dead_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DEAD) |=> (!act_a_q && !act_b_q));
    // R8
    kill_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (!act_a_q && !act_b_q));
    // R4
    rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(act_a_q) || $rose(act_b_q)) |-> $past(period_start));
    // R5
    steer_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> (steer_q != $past(steer_q)));
endmodule

// File: tb/sim_pp_pwm_ctrl.sv
// Scoreboard bench: the driver predicts each period's pulse (side, first
// visible cycle, width); the monitor measures pulses and compares.
module sim_pp_pwm_ctrl;
    localparam int CLK_NS = 10;
    localparam int CW     = 8;
    localparam int STEP   = 4;
    localparam int RL     = 16;
    localparam int DL     = 6;
    localparam int PL     = RL + DL;
    localparam int SSMAX  = 255;

    typedef struct {
        bit side;
        int start;
        int width;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] ramp_len = CW'(RL);
    logic [CW-1:0] dead_len = CW'(DL);
    logic [CW-1:0] duty = '0;
    logic          sync_in = 1'b0;
    logic          shdn = 1'b0;
    logic          uvlo = 1'b0;
    logic          a0, b0, a1, b1;

    exp_t q[$];
    int   cyc = 0;
    int   n_test = 0;
    int   n_fail = 0;
    int   base = DL;
    int   ss = 0;
    bit   side = 1'b0;
    int   pol_bad = 0;
    int   ovl_bad = 0;
    bit   in_a = 0, in_b = 0;
    int   st_a = 0, st_b = 0;

    pp_pwm_ctrl #(.CNT_W(CW), .SS_STEP(STEP), .OFF_HIGH(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .ramp_len(ramp_len), .dead_len(dead_len),
        .duty_cmd(duty), .sync_in(sync_in), .shdn_in(shdn), .uvlo_in(uvlo),
        .out_a(a0), .out_b(b0));

    pp_pwm_ctrl #(.CNT_W(CW), .SS_STEP(STEP), .OFF_HIGH(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .ramp_len(ramp_len), .dead_len(dead_len),
        .duty_cmd(duty), .sync_in(sync_in), .shdn_in(shdn), .uvlo_in(uvlo),
        .out_a(a1), .out_b(b1));

    always #(CLK_NS/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_test++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Compare one measured pulse against the front of the scoreboard.
    task automatic score(input bit s, input int st, input int w);
        exp_t e;
        if (q.size() == 0) begin
            check(1'b0, "R4 unexpected pulse", st, -1);
            return;
        end
        e = q.pop_front();
        check(s == e.side, "R5 side", int'(s), int'(e.side));
        check(st == e.start, "R1 start cycle", st, e.start);
        check(w == e.width, "R2 width", w, e.width);
    endtask

    // Monitor: polarity, overlap and pulse measurement, sampled at negedge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (a1 !== ~a0 || b1 !== ~b0) pol_bad++;
            if (a0 && b0) ovl_bad++;
            if (a0 && !in_a) begin in_a = 1; st_a = cyc; end
            if (!a0 && in_a) begin in_a = 0; score(1'b0, st_a, cyc - st_a); end
            if (b0 && !in_b) begin in_b = 1; st_b = cyc; end
            if (!b0 && in_b) begin in_b = 0; score(1'b1, st_b, cyc - st_b); end
        end
    end

    // Driver for one period. mode: 0 plain, 1 mid-pulse shutdown,
    // 2 duty raised after the pulse ends, 3 restart issued in dead time.
    task automatic do_period(input int dty, input bit sd, input bit uv, input int mode);
        int w;
        wait_cyc(base - DL);
        duty = CW'(dty);
        shdn = sd;
        uvlo = uv;
        if (mode == 3) begin
            wait_cyc(base - DL + 2);
            sync_in = 1'b1;
            wait_cyc(base - DL + 3);
            sync_in = 1'b0;
            base = base - DL + 3;   // R11: period starts right after restart
        end
        if (uv)      ss = 0;                                  // R10
        else if (sd) ss = (ss >= 2*STEP) ? ss - 2*STEP : 0;   // R9
        else         ss = (ss + STEP > SSMAX) ? SSMAX : ss + STEP;
        w = (sd || uv) ? 0 : dty;                              // R3
        if (ss < w) w = ss;
        if (RL < w) w = RL;
        if (mode == 1 && w > 3) w = 3;                         // R8
        if (w > 0) q.push_back('{side, base + 1, w});
        side = ~side;
        if (mode == 1) begin
            wait_cyc(base + 1);
            shdn = 1'b1;
            wait_cyc(base + 4);
            shdn = 1'b0;                                       // R4: no restart
        end
        if (mode == 2) begin
            wait_cyc(base + w + 1);
            duty = CW'(40);                                    // R4: latch holds
        end
        base = base + PL;
    endtask

    initial begin : watchdog
        #(CLK_NS * 20000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_test + 1, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        // R7 reset state of both polarity variants
        check(a0 == 1'b0 && b0 == 1'b0, "R7 reset idle low", int'({a0, b0}), 0);
        check(a1 == 1'b1 && b1 == 1'b1, "R7 reset idle high", int'({a1, b1}), 3);
        rst_n = 1'b1;
        // R9 soft-start ramp with R3 duty limiting
        do_period(12, 0, 0, 0);
        do_period(12, 0, 0, 0);
        do_period(12, 0, 0, 0);
        do_period(12, 0, 0, 0);
        // R2 width bounded by the ramp phase
        do_period(40, 0, 0, 0);
        do_period(40, 0, 0, 0);
        // R2 zero duty, R5 steering still toggles
        do_period(0, 0, 0, 0);
        do_period(40, 0, 0, 0);
        // R8/R9 shutdown drains at twice the rate, then slow recovery
        do_period(40, 1, 0, 0);
        do_period(40, 1, 0, 0);
        do_period(40, 1, 0, 0);
        do_period(40, 1, 0, 0);
        do_period(40, 0, 0, 0);
        do_period(40, 0, 0, 0);
        do_period(40, 0, 0, 0);
        do_period(40, 0, 0, 0);
        do_period(40, 0, 0, 0);
        // R4/R8 mid-pulse shutdown and release
        do_period(40, 0, 0, 1);
        // R4 duty raised after termination
        do_period(5, 0, 0, 2);
        // R10 lockout clears soft-start
        do_period(40, 0, 1, 0);
        do_period(40, 0, 0, 0);
        do_period(40, 0, 0, 0);
        // R11 restart in dead time
        do_period(40, 0, 0, 3);
        do_period(40, 0, 0, 0);
        wait_cyc(base + 2);
        check(q.size() == 0, "R2 all expected pulses seen", q.size(), 0);
        check(pol_bad == 0, "R7 inverted variant matches", pol_bad, 0);
        check(ovl_bad == 0, "R6 outputs never both active", ovl_bad, 0);
        $display("[TB] %0d tests run, %0d failed", n_test, n_fail);
        $finish;
    end
endmodule